// File: doc/BRIEF.md
# Shared-Bus 32x8 Static RAM

A small static memory of 32 eight-bit words that sits on the data bus of a simple 8-bit processor. The processor selects it with an active-low select line and controls it with active-low read and write lines. Inside the model, the single bidirectional data pin is split into a data input, a data output and an output enable, so that a pad or bus multiplexer outside the block can rebuild the shared line. The block drives the bus only when it is selected and reading. Read has priority over write, so a write strobe seen during a read never alters the array.

Writes are judged against the system clock. A timing monitor counts the clock edges at which address, select and data hold steady around the write strobe. The monitor also counts the edges at which the strobe is low. A strobe that breaks any limit is dropped, and a sticky error flag is raised that only reset clears. A correct strobe is written into the array once the data-hold window after the strobe's release has passed. Read data comes straight from the array by default; a parameter adds one register stage. Array contents are not reset.

Top module: `shbus_sram`

## Requirements
- R1: The array keeps 32 independent 8-bit words, chosen by the 5-bit `addr`; every word written with a correct strobe reads back unchanged.
- R2: With `sel_n`=0 and `rd_n`=0 the block is reading: `doe`=1 and `dout` equals the stored word at `addr` in the same cycle (default `READ_LAT`=0), whatever the value of `wr_n`.
- R3: With `sel_n`=1, `doe`=0 and `dout`=0 for every combination of `rd_n` and `wr_n`. A write strobe during which `sel_n` stays 1 writes nothing and raises no error.
- R4: With `sel_n`=0 and `rd_n`=1 (write mode when `wr_n`=0, standby when `wr_n`=1), `doe`=0 and `dout`=0.
- R5: A write strobe during which `rd_n` is sampled 0 at any edge leaves the array unchanged and raises no error.
- R6: A strobe ends at the first clock edge E that samples `wr_n`=1 after edges that sampled it 0. The address and data sampled at E are written at edge E+`DATA_HOLD` (default E+1). A read between E and that edge still returns the old word.
- R7: `addr` must hold its value for at least `ADDR_SETUP` (2) edges before the first edge that samples the strobe low. `sel_n` must be 0 at at least `CSEL_SETUP` (2) edges before that edge. Both must stay unchanged until E. Otherwise the write is dropped and `werr` is set.
- R8: The strobe must be sampled 0 at no fewer than `MIN_PULSE` (2) edges; a shorter strobe is dropped and sets `werr`.
- R9: `din` must already carry its final value at least `DATA_SETUP` (1) edges before E. Otherwise the write is dropped and `werr` is set.
- R10: `din` must stay unchanged at each of the `DATA_HOLD` (1) edges after E. Otherwise the write is dropped and `werr` is set.
- R11: `werr` reads 0 after reset and, once set, stays 1 through later correct writes until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all sampling on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 5 | Word address |
| sel_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read enable; wins over the write enable |
| wr_n | input | 1 | Active-low write strobe |
| din | input | 8 | Data-in half of the shared bus |
| dout | output | 8 | Data-out half of the shared bus; 0 when not driving |
| doe | output | 1 | Output enable for the shared bus driver |
| werr | output | 1 | Sticky write-timing error flag |

## Verification
The hardest case to reach from the ports is a data-hold violation. A strobe passes every check up to its release edge and the write is already pending. Then `din` changes at the single edge that follows, and the write must be dropped without leaving a trace in the array. The bench drives every input on the falling clock edge from one parameterised write task. Each knob of that task (address lead, select lead, strobe width, late data, hold break, read overlap) moves one transition by exactly one rising edge. Each violation therefore breaks exactly one rule, while a known word sits at the target address.

// File: rtl/shbus_sram_pkg.sv
package shbus_sram_pkg;

  typedef enum logic [1:0] {
    BUS_OFF   = 2'd0,
    BUS_IDLE  = 2'd1,
    BUS_WRITE = 2'd2,
    BUS_READ  = 2'd3
  } bus_mode_e;

  function automatic int max_of5(input int a, input int b, input int c,
                                 input int d, input int e);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    return m;
  endfunction

endpackage

// File: rtl/shbus_sram_decode.sv
module shbus_sram_decode
  import shbus_sram_pkg::*;
(
  input  logic      sel_n,
  input  logic      rd_n,
  input  logic      wr_n,
  output bus_mode_e mode
);

  // read enable outranks the write strobe
  always_comb begin
    if (sel_n)      mode = BUS_OFF;
    else if (!rd_n) mode = BUS_READ;
    else if (!wr_n) mode = BUS_WRITE;
    else            mode = BUS_IDLE;
  end

endmodule

// File: rtl/shbus_sram_wmon.sv
module shbus_sram_wmon #(
  parameter int AW         = 5,
  parameter int DW         = 8,
  parameter int ADDR_SETUP = 2,
  parameter int CSEL_SETUP = 2,
  parameter int DATA_SETUP = 1,
  parameter int DATA_HOLD  = 1,
  parameter int MIN_PULSE  = 2,
  parameter bit CHECK_EN   = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic          sel_n,
  input  logic          rd_n,
  input  logic          wr_n,
  output logic          commit,
  output logic [AW-1:0] commit_addr,
  output logic [DW-1:0] commit_data,
  output logic          viol
);

  localparam int MAXP = shbus_sram_pkg::max_of5(ADDR_SETUP, CSEL_SETUP,
                                                DATA_SETUP, DATA_HOLD, MIN_PULSE);
  localparam int CW = $clog2(MAXP + 2);
  localparam logic [CW-1:0] CNT_TOP = CW'(MAXP);

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] v);
    return (v == CNT_TOP) ? v : v + CW'(1);
  endfunction

  // input history
  logic [AW-1:0] addr_q;
  logic [DW-1:0] din_q;
  logic [CW-1:0] aage_q, aage_n, dage_q, dage_n, sage_q, sage_n;
  // strobe tracking
  logic          wr_q;
  logic          busy_q, busy_n, spoil_q, spoil_n, bad_q, bad_n;
  logic [CW-1:0] pcnt_q, pcnt_n;
  // hold window
  logic          pend_q, pend_n;
  logic [CW-1:0] hcnt_q, hcnt_n;
  logic [AW-1:0] cap_a_q, cap_a_n;
  logic [DW-1:0] cap_d_q, cap_d_n;

  logic addr_same, din_same;
  logic stb_start, stb_mid, stb_end;
  logic start_ok, end_ok, take, pass, viol_end, hold_fail, hold_done;

  assign addr_same = (addr == addr_q);
  assign din_same  = (din == din_q);
  assign stb_start = !wr_n && wr_q;
  assign stb_mid   = !wr_n && !wr_q && busy_q;
  assign stb_end   = wr_n && !wr_q && busy_q;

  assign start_ok = addr_same && (aage_q >= CW'(ADDR_SETUP)) &&
                    !sel_n && (sage_q >= CW'(CSEL_SETUP));
  assign end_ok   = !bad_q && addr_same && !sel_n &&
                    (pcnt_q >= CW'(MIN_PULSE)) &&
                    din_same && (dage_q >= CW'(DATA_SETUP));

  assign take      = stb_end && !spoil_q;
  assign pass      = take && (end_ok || !CHECK_EN);
  assign viol_end  = take && CHECK_EN && !end_ok;
  assign hold_fail = pend_q && CHECK_EN && (din != cap_d_q);
  assign hold_done = pend_q && !hold_fail && (hcnt_q == CW'(1));
  assign viol      = viol_end || hold_fail;

  always_comb begin
    aage_n  = addr_same ? bump(aage_q) : CW'(1);
    dage_n  = din_same  ? bump(dage_q) : CW'(1);
    sage_n  = sel_n ? '0 : bump(sage_q);
    busy_n  = busy_q;
    spoil_n = spoil_q;
    bad_n   = bad_q;
    pcnt_n  = pcnt_q;
    if (stb_start) begin
      busy_n  = !sel_n;
      spoil_n = !rd_n;
      bad_n   = CHECK_EN && !start_ok;
      pcnt_n  = CW'(1);
    end else if (stb_mid) begin
      pcnt_n = bump(pcnt_q);
      if (!rd_n) spoil_n = 1'b1;
      if (CHECK_EN && (!addr_same || sel_n)) bad_n = 1'b1;
    end else if (stb_end) begin
      busy_n = 1'b0;
    end
  end

  always_comb begin
    pend_n  = pend_q;
    hcnt_n  = hcnt_q;
    cap_a_n = cap_a_q;
    cap_d_n = cap_d_q;
    if (pend_q) begin
      if (hold_fail || hold_done) pend_n = 1'b0;
      else                        hcnt_n = hcnt_q - CW'(1);
    end
    if (pass && (DATA_HOLD > 0)) begin
      pend_n  = 1'b1;
      hcnt_n  = CW'(DATA_HOLD);
      cap_a_n = addr;
      cap_d_n = din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      din_q   <= '0;
      aage_q  <= '0;
      dage_q  <= '0;
      sage_q  <= '0;
      wr_q    <= 1'b1;
      busy_q  <= 1'b0;
      spoil_q <= 1'b0;
      bad_q   <= 1'b0;
      pcnt_q  <= '0;
      pend_q  <= 1'b0;
      hcnt_q  <= '0;
      cap_a_q <= '0;
      cap_d_q <= '0;
    end else begin
      addr_q  <= addr;
      din_q   <= din;
      aage_q  <= aage_n;
      dage_q  <= dage_n;
      sage_q  <= sage_n;
      wr_q    <= wr_n;
      busy_q  <= busy_n;
      spoil_q <= spoil_n;
      bad_q   <= bad_n;
      pcnt_q  <= pcnt_n;
      pend_q  <= pend_n;
      hcnt_q  <= hcnt_n;
      cap_a_q <= cap_a_n;
      cap_d_q <= cap_d_n;
    end
  end

  generate
    if (DATA_HOLD == 0) begin : g_nohold
      assign commit      = pass;
      assign commit_addr = addr;
      assign commit_data = din;
    end else begin : g_hold
      assign commit      = hold_done;
      assign commit_addr = cap_a_q;
      assign commit_data = cap_d_q;
    end
  endgenerate

  AST_COMMIT_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (CHECK_EN && (DATA_HOLD > 0) && commit) |-> (din == $past(din)))
    else $error("commit while data moved"); // R10

  AST_SHORT_PULSE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (CHECK_EN && take && (pcnt_q < CW'(MIN_PULSE))) |-> (viol && !commit_from_end()))
    else $error("short strobe not flagged"); // R8

  function automatic logic commit_from_end();
    return (DATA_HOLD == 0) && commit;
  endfunction

  AST_SPOILED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_end && spoil_q && !pend_q) |-> !viol)
    else $error("read-overridden strobe raised error"); // R5

endmodule

// File: rtl/shbus_sram_array.sv
module shbus_sram_array #(
  parameter int AW       = 5,
  parameter int DW       = 8,
  parameter int READ_LAT = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rd_en,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // storage is not reset
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  generate
    if (READ_LAT == 0) begin : g_comb_rd
      logic unused_rd;
      assign unused_rd = rd_en ^ rst_n;
      assign rdata = mem[raddr];
    end else begin : g_reg_rd
      logic [DW-1:0] rdata_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= mem[raddr];
      end
      assign rdata = rdata_q;
    end
  endgenerate

endmodule

// File: rtl/shbus_sram.sv
module shbus_sram #(
  parameter int AW         = 5,
  parameter int DW         = 8,
  parameter int ADDR_SETUP = 2,
  parameter int CSEL_SETUP = 2,
  parameter int DATA_SETUP = 1,
  parameter int DATA_HOLD  = 1,
  parameter int MIN_PULSE  = 2,
  parameter bit CHECK_EN   = 1'b1,
  parameter int READ_LAT   = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          sel_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          doe,
  output logic          werr
);
  import shbus_sram_pkg::*;

  // reset: asserted at once, released on the clock
  logic [1:0] rsync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_s = rsync_q[1];

  bus_mode_e     mode;
  logic          commit, viol;
  logic [AW-1:0] c_addr;
  logic [DW-1:0] c_data, rdata;
  logic          err_q, err_n;

  shbus_sram_decode u_dec (
    .sel_n (sel_n),
    .rd_n  (rd_n),
    .wr_n  (wr_n),
    .mode  (mode)
  );

  shbus_sram_wmon #(
    .AW(AW), .DW(DW), .ADDR_SETUP(ADDR_SETUP), .CSEL_SETUP(CSEL_SETUP),
    .DATA_SETUP(DATA_SETUP), .DATA_HOLD(DATA_HOLD), .MIN_PULSE(MIN_PULSE),
    .CHECK_EN(CHECK_EN)
  ) u_mon (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .addr        (addr),
    .din         (din),
    .sel_n       (sel_n),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .commit      (commit),
    .commit_addr (c_addr),
    .commit_data (c_data),
    .viol        (viol)
  );

  shbus_sram_array #(.AW(AW), .DW(DW), .READ_LAT(READ_LAT)) u_arr (
    .clk   (clk),
    .rst_n (rst_n_s),
    .we    (commit),
    .waddr (c_addr),
    .wdata (c_data),
    .rd_en (doe),
    .raddr (addr),
    .rdata (rdata)
  );

  assign doe  = (mode == BUS_READ);
  assign dout = doe ? rdata : '0;

  always_comb begin
    err_n = err_q;
    if (viol) err_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) err_q <= 1'b0;
    else          err_q <= err_n;
  end
  assign werr = err_q;

  AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n_s)
    doe |-> (!sel_n && !rd_n))
    else $error("bus driven outside read"); // R3

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n_s)
    $past(werr) |-> werr)
    else $error("error flag cleared without reset"); // R11

  AST_ERR_ON_VIOL: assert property (@(posedge clk) disable iff (!rst_n_s)
    viol |=> werr)
    else $error("violation not recorded"); // R7

endmodule

// File: tb/shbus_sram_test.sv
module shbus_sram_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] addr;
  logic       sel_n, rd_n, wr_n;
  logic [7:0] din;
  logic [7:0] dout;
  logic       doe, werr;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [7:0] shadow [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  shbus_sram uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .sel_n(sel_n), .rd_n(rd_n),
    .wr_n(wr_n), .din(din), .dout(dout), .doe(doe), .werr(werr)
  );

  function automatic logic [7:0] pat(input logic [4:0] a);
    return {a[2:0], a} ^ 8'hA5;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [7:0] act,
                     input logic [7:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sel_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    addr = '0; din = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // a_pre/s_pre: edges that see address/select before the strobe (-1: never)
  task automatic wr(input logic [4:0] a, input logic [7:0] d, input int a_pre,
                    input int s_pre, input int width, input bit d_late,
                    input bit h_break, input bit rd_low);
    @(negedge clk);
    sel_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    addr = ~a;
    din = d_late ? ~d : d;
    for (int k = 3; k > 0; k--) begin
      if (k == a_pre) addr = a;
      if (k == s_pre) sel_n = 1'b0;
      @(negedge clk);
    end
    if (a_pre == 0) addr = a;
    if (s_pre == 0) sel_n = 1'b0;
    rd_n = rd_low ? 1'b0 : 1'b1;
    wr_n = 1'b0;
    repeat (width) @(negedge clk);
    if (d_late) din = d;
    wr_n = 1'b1;
    rd_n = 1'b1;
    @(negedge clk);
    if (h_break) din = ~d;
    repeat (2) @(negedge clk);
  endtask

  task automatic good_wr(input logic [4:0] a, input logic [7:0] d);
    wr(a, d, 2, 2, 2, 1'b0, 1'b0, 1'b0);
    shadow[a] = d;
  endtask

  task automatic rd_chk(input logic [4:0] a, input string tag);
    @(negedge clk);
    sel_n = 1'b0; rd_n = 1'b0; addr = a;
    #1;
    chk(doe === 1'b1, {tag, " doe"}, {7'd0, doe}, 8'd1);
    chk(dout === shadow[a], {tag, " data"}, dout, shadow[a]);
    rd_n = 1'b1;
  endtask

  task automatic t_reset_state();
    do_reset();
    #1;
    chk(doe === 1'b0, "R11 reset doe", {7'd0, doe}, 8'd0);
    chk(werr === 1'b0, "R11 reset werr", {7'd0, werr}, 8'd0);
  endtask

  task automatic t_fill_all();
    for (int a = 0; a < 32; a++) good_wr(5'(a), pat(5'(a)));
    for (int a = 0; a < 32; a++) begin
      @(negedge clk);
      sel_n = 1'b0; rd_n = 1'b0; addr = 5'(a);
      #1;
      chk(dout === shadow[a], "R1 word readback", dout, shadow[a]);
    end
    rd_n = 1'b1;
    good_wr(5'd9, 8'h00);
    good_wr(5'd10, 8'hFF);
    rd_chk(5'd9, "R1 zero word");
    rd_chk(5'd10, "R1 ones word");
    rd_chk(5'd11, "R1 neighbour intact");
  endtask

  task automatic t_read_priority();
    @(negedge clk);
    sel_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0; addr = 5'd7; din = 8'h3C;
    #1;
    chk(doe === 1'b1, "R2 doe with wr low", {7'd0, doe}, 8'd1);
    chk(dout === shadow[7], "R2 data with wr low", dout, shadow[7]);
    repeat (2) @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    rd_n = 1'b1;
    rd_chk(5'd7, "R2 word kept");
  endtask

  task automatic t_deselect();
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      sel_n = 1'b1; rd_n = c[0]; wr_n = c[1];
      #1;
      chk(doe === 1'b0 && dout === 8'h00, "R3 deselected released", dout, 8'h00);
    end
    wr_n = 1'b1;
    wr(5'd4, 8'h5A, 2, -1, 2, 1'b0, 1'b0, 1'b0);
    rd_chk(5'd4, "R3 strobe while deselected");
    chk(werr === 1'b0, "R3 no error when deselected", {7'd0, werr}, 8'd0);
  endtask

  task automatic t_standby_and_commit();
    logic [7:0] old;
    old = shadow[12];
    @(negedge clk);
    sel_n = 1'b0; rd_n = 1'b1; wr_n = 1'b1; addr = 5'd12; din = 8'hC3;
    #1;
    chk(doe === 1'b0 && dout === 8'h00, "R4 standby released", dout, 8'h00);
    repeat (2) @(negedge clk);
    wr_n = 1'b0;
    #1;
    chk(doe === 1'b0 && dout === 8'h00, "R4 write mode released", dout, 8'h00);
    repeat (2) @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    rd_n = 1'b0;
    #1;
    chk(dout === old, "R6 old word before hold edge", dout, old);
    @(negedge clk);
    #1;
    chk(dout === 8'hC3, "R6 new word after hold edge", dout, 8'hC3);
    rd_n = 1'b1;
    shadow[12] = 8'hC3;
  endtask

  task automatic t_override();
    wr(5'd15, 8'h96, 2, 2, 2, 1'b0, 1'b0, 1'b1);
    rd_chk(5'd15, "R5 read overrides write");
    chk(werr === 1'b0, "R5 no error on override", {7'd0, werr}, 8'd0);
  endtask

  task automatic t_violation(input int a_pre, input int s_pre, input int width,
                             input bit d_late, input bit h_break, input string tag);
    do_reset();
    good_wr(5'd20, 8'h11);
    wr(5'd20, 8'hEE, a_pre, s_pre, width, d_late, h_break, 1'b0);
    #1;
    chk(werr === 1'b1, {tag, " error set"}, {7'd0, werr}, 8'd1);
    rd_chk(5'd20, {tag, " write dropped"});
  endtask

  task automatic t_sticky();
    good_wr(5'd21, 8'h42);
    rd_chk(5'd21, "R11 later good write");
    chk(werr === 1'b1, "R11 error stays", {7'd0, werr}, 8'd1);
    do_reset();
    #1;
    chk(werr === 1'b0, "R11 reset clears error", {7'd0, werr}, 8'd0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 8'd0, 8'd1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sel_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; addr = '0; din = '0;
    t_reset_state();
    t_fill_all();
    t_read_priority();
    t_deselect();
    t_standby_and_commit();
    t_override();
    t_violation(1, 2, 2, 1'b0, 1'b0, "R7 address setup");
    t_violation(2, 1, 2, 1'b0, 1'b0, "R7 select setup");
    t_violation(2, 2, 1, 1'b0, 1'b0, "R8 short strobe");
    t_violation(2, 2, 2, 1'b1, 1'b0, "R9 late data");
    t_violation(2, 2, 2, 1'b0, 1'b1, "R10 hold break");
    t_sticky();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule